// File: doc/BRIEF.md
# Operand Fetch and Shift Stage

This block sits between instruction decode and the ALU of a 32-bit RISC core. It takes the decoded register fields of a data-processing instruction and reads the two data operands from a register file that has only two read ports. It then passes the second operand through a four-mode barrel shifter and presents the first operand, the shifted second operand and the shifter carry-out to the ALU, qualified by a valid strobe.

Register 15 is the program counter. Reads of register 15 never reach the register file; the block supplies the value itself from the instruction address. When the shift amount is an immediate, everything is fetched in one cycle. When the shift amount comes from a register, three reads are needed, so the block spends an extra cycle. The amount register is read first, and the data operands are read in the following cycle. The program counter has advanced by 4 by that second cycle.

Top module: `operand_fetch_shift`

## Requirements
- R1: When a request is accepted with `shift_by_reg_i` low, read port A addresses `rn_i`, read port B addresses `rm_i`, and `out_valid_o` is high in that same cycle with the results.
- R2: When a request is accepted with `shift_by_reg_i` high, port A addresses `rs_i` and `out_valid_o` stays low in that cycle. In the next cycle `out_valid_o` is high, `in_ready_o` is low, and the results are computed from the operands read in that cycle.
- R3: With an immediate shift amount, an operand field equal to 15 in either position yields `instr_addr_i + 8`.
- R4: With a register shift amount, an operand field equal to 15 in either position yields the instruction address plus 12. An `rs_i` of 15 yields the address plus 8.
- R5: For a register shift, only bits [7:0] of the amount register are used. The upper 24 bits have no effect.
- R6: A shift amount of 0 passes the second operand through unchanged, and `carry_o` equals `carry_i`.
- R7: Type 0 is a logical left shift. For n < 32, carry is bit 32-n of the input. For n = 32, the result is 0 and carry is bit 0. For n > 32, both are 0.
- R8: Type 1 is a logical right shift. For n < 32, carry is bit n-1. For n = 32, the result is 0 and carry is bit 31. For n > 32, both are 0.
- R9: Type 2 is an arithmetic right shift. For n < 32, carry is bit n-1. For n >= 32, every result bit and the carry equal bit 31.
- R10: Type 3 is a rotate right by n mod 32. The carry is bit 31 of the result. When n is a non-zero multiple of 32, the operand is unchanged and carry is bit 31.
- R11: After reset `out_valid_o` is low and `in_ready_o` is high.
- R12: While `in_ready_o` is low, `in_valid_i` and all request fields are ignored. The pending instruction completes with its own fields, and `in_ready_o` returns high the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request present |
| in_ready_o | output | 1 | Block can accept a request |
| rn_i | input | 4 | First-operand register index |
| rm_i | input | 4 | Second-operand register index |
| rs_i | input | 4 | Shift-amount register index |
| shift_type_i | input | 2 | 0 LSL, 1 LSR, 2 ASR, 3 ROR |
| shift_by_reg_i | input | 1 | Amount comes from register `rs_i` |
| shift_imm_i | input | 5 | Immediate shift amount |
| carry_i | input | 1 | Current carry flag |
| instr_addr_i | input | 32 | Address of the executing instruction |
| rf_raddr_a_o | output | 4 | Register file port A address |
| rf_raddr_b_o | output | 4 | Register file port B address |
| rf_rdata_a_i | input | 32 | Register file port A data (combinational) |
| rf_rdata_b_i | input | 32 | Register file port B data (combinational) |
| op_a_o | output | 32 | First operand |
| op_b_o | output | 32 | Shifted second operand |
| carry_o | output | 1 | Shifter carry-out |
| out_valid_o | output | 1 | Outputs valid |

## Verification
If the busy flag is wrong, the error appears at the ports within one cycle. `in_ready_o` and `out_valid_o` then disagree with the cycle count of R1 and R2. A register-shift result could also appear in its first cycle, while port A still carries `rs_i`. A stale program-counter register, or an offset applied in the wrong cycle, shows only when 15 is an operand. For that reason the bench drives register 15 into every position under both amount sources. If latched request fields are wrong, the second-cycle outputs are wrong. The bench exposes this by driving unrelated fields during the busy cycle.

// File: rtl/opf_pkg.sv
package opf_pkg;
  localparam int unsigned XLEN   = 32;
  localparam int unsigned RIDX_W = 4;
  localparam int unsigned AMT_W  = 8;
  localparam int unsigned PC_IDX = 15;

  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } shift_e;
endpackage

// File: rtl/opf_pc_sub.sv
module opf_pc_sub #(
  parameter int unsigned W      = 32,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned PC_IDX = 15
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic [W-1:0]     rf_data_i,
  input  logic [W-1:0]     pc_i,
  output logic [W-1:0]     data_o
);
  localparam logic [IDX_W-1:0] PC_SEL = IDX_W'(PC_IDX);
  assign data_o = (idx_i == PC_SEL) ? pc_i : rf_data_i;
endmodule

// File: rtl/opf_barrel_shifter.sv
module opf_barrel_shifter
  import opf_pkg::*;
#(
  parameter int unsigned W     = 32,
  parameter int unsigned AMT_W = 8
) (
  input  logic [W-1:0]     val_i,
  input  shift_e           type_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic             carry_i,
  output logic [W-1:0]     res_o,
  output logic             carry_o
);
  localparam int unsigned SH_W = $clog2(W);
  localparam logic [AMT_W-1:0] W_AMT = AMT_W'(W);
  localparam logic [SH_W:0]    W_ROT = (SH_W+1)'(W);

  logic [SH_W-1:0] lo_idx, hi_idx, rot;
  logic [W-1:0]    rot_val;

  assign lo_idx  = SH_W'(amt_i - 1'b1);
  assign hi_idx  = SH_W'(W_AMT - amt_i);
  assign rot     = amt_i[SH_W-1:0];
  assign rot_val = (val_i >> rot) | (val_i << (W_ROT - {1'b0, rot}));

  always_comb begin
    res_o   = val_i;
    carry_o = carry_i;
    if (amt_i != '0) begin
      unique case (type_i)
        SH_LSL: begin
          res_o = (amt_i < W_AMT) ? (val_i << amt_i) : '0;
          if (amt_i < W_AMT)       carry_o = val_i[hi_idx];
          else if (amt_i == W_AMT) carry_o = val_i[0];
          else                     carry_o = 1'b0;
        end
        SH_LSR: begin
          res_o = (amt_i < W_AMT) ? (val_i >> amt_i) : '0;
          if (amt_i < W_AMT)       carry_o = val_i[lo_idx];
          else if (amt_i == W_AMT) carry_o = val_i[W-1];
          else                     carry_o = 1'b0;
        end
        SH_ASR: begin
          res_o   = (amt_i < W_AMT) ? W'($signed(val_i) >>> amt_i) : {W{val_i[W-1]}};
          carry_o = (amt_i < W_AMT) ? val_i[lo_idx] : val_i[W-1];
        end
        default: begin
          res_o   = (rot == '0) ? val_i : rot_val;
          carry_o = res_o[W-1];
        end
      endcase
    end
  end
endmodule

// File: rtl/opf_sequencer.sv
module opf_sequencer
  import opf_pkg::*;
#(
  parameter int unsigned W     = 32,
  parameter int unsigned IDX_W = 4,
  parameter int unsigned AMT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [IDX_W-1:0] rn_i,
  input  logic [IDX_W-1:0] rm_i,
  input  logic [IDX_W-1:0] rs_i,
  input  shift_e           type_i,
  input  logic             by_reg_i,
  input  logic [4:0]       imm_i,
  input  logic             carry_i,
  input  logic [W-1:0]     addr_i,
  input  logic [W-1:0]     port_a_i,
  output logic             in_ready_o,
  output logic             out_valid_o,
  output logic [IDX_W-1:0] raddr_a_o,
  output logic [IDX_W-1:0] raddr_b_o,
  output logic [W-1:0]     pc_o,
  output shift_e           type_o,
  output logic [AMT_W-1:0] amt_o,
  output logic             carry_o
);
  logic             busy_q;
  logic [IDX_W-1:0] rn_q, rm_q;
  shift_e           type_q;
  logic [AMT_W-1:0] amt_q;
  logic             carry_q;
  logic [W-1:0]     pc_q;
  logic             take_reg;

  assign take_reg = in_valid_i && !busy_q && by_reg_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      rn_q    <= '0;
      rm_q    <= '0;
      type_q  <= SH_LSL;
      amt_q   <= '0;
      carry_q <= 1'b0;
      pc_q    <= '0;
    end else if (busy_q) begin
      busy_q <= 1'b0;
    end else if (take_reg) begin
      busy_q  <= 1'b1;
      rn_q    <= rn_i;
      rm_q    <= rm_i;
      type_q  <= type_i;
      amt_q   <= port_a_i[AMT_W-1:0];
      carry_q <= carry_i;
      pc_q    <= addr_i + W'(12);  // pc advanced by 4 after cycle one
    end
  end

  assign in_ready_o  = !busy_q;
  assign out_valid_o = busy_q || (in_valid_i && !by_reg_i);
  assign raddr_a_o   = busy_q ? rn_q : (by_reg_i ? rs_i : rn_i);
  assign raddr_b_o   = busy_q ? rm_q : rm_i;
  assign pc_o        = busy_q ? pc_q : addr_i + W'(8);
  assign type_o      = busy_q ? type_q : type_i;
  assign amt_o       = busy_q ? amt_q : AMT_W'(imm_i);
  assign carry_o     = busy_q ? carry_q : carry_i;
endmodule

// File: rtl/operand_fetch_shift.sv
module operand_fetch_shift
  import opf_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                in_valid_i,
  output logic                in_ready_o,
  input  logic [RIDX_W-1:0]   rn_i,
  input  logic [RIDX_W-1:0]   rm_i,
  input  logic [RIDX_W-1:0]   rs_i,
  input  logic [1:0]          shift_type_i,
  input  logic                shift_by_reg_i,
  input  logic [4:0]          shift_imm_i,
  input  logic                carry_i,
  input  logic [XLEN-1:0]     instr_addr_i,
  output logic [RIDX_W-1:0]   rf_raddr_a_o,
  output logic [RIDX_W-1:0]   rf_raddr_b_o,
  input  logic [XLEN-1:0]     rf_rdata_a_i,
  input  logic [XLEN-1:0]     rf_rdata_b_i,
  output logic [XLEN-1:0]     op_a_o,
  output logic [XLEN-1:0]     op_b_o,
  output logic                carry_o
  ,output logic               out_valid_o
);
  logic [XLEN-1:0]  pc_val, port_a, port_b;
  shift_e           sh_type;
  logic [AMT_W-1:0] sh_amt;
  logic             sh_cin;

  opf_sequencer #(.W(XLEN), .IDX_W(RIDX_W), .AMT_W(AMT_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .rn_i       (rn_i),
    .rm_i       (rm_i),
    .rs_i       (rs_i),
    .type_i     (shift_e'(shift_type_i)),
    .by_reg_i   (shift_by_reg_i),
    .imm_i      (shift_imm_i),
    .carry_i    (carry_i),
    .addr_i     (instr_addr_i),
    .port_a_i   (port_a),
    .in_ready_o (in_ready_o),
    .out_valid_o(out_valid_o),
    .raddr_a_o  (rf_raddr_a_o),
    .raddr_b_o  (rf_raddr_b_o),
    .pc_o       (pc_val),
    .type_o     (sh_type),
    .amt_o      (sh_amt),
    .carry_o    (sh_cin)
  );

  opf_pc_sub #(.W(XLEN), .IDX_W(RIDX_W), .PC_IDX(PC_IDX)) u_sub_a (
    .idx_i(rf_raddr_a_o), .rf_data_i(rf_rdata_a_i), .pc_i(pc_val), .data_o(port_a)
  );

  opf_pc_sub #(.W(XLEN), .IDX_W(RIDX_W), .PC_IDX(PC_IDX)) u_sub_b (
    .idx_i(rf_raddr_b_o), .rf_data_i(rf_rdata_b_i), .pc_i(pc_val), .data_o(port_b)
  );

  opf_barrel_shifter #(.W(XLEN), .AMT_W(AMT_W)) u_shift (
    .val_i  (port_b),
    .type_i (sh_type),
    .amt_i  (sh_amt),
    .carry_i(sh_cin),
    .res_o  (op_b_o),
    .carry_o(carry_o)
  );

  assign op_a_o = port_a;
endmodule

// File: rtl/opf_checker.sv
module opf_checker
  import opf_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic [RIDX_W-1:0] rn_i,
  input logic [RIDX_W-1:0] rm_i,
  input logic [RIDX_W-1:0] rs_i,
  input logic              shift_by_reg_i,
  input logic [4:0]        shift_imm_i,
  input logic              carry_i,
  input logic [XLEN-1:0]   instr_addr_i,
  input logic [RIDX_W-1:0] rf_raddr_a_o,
  input logic [XLEN-1:0]   rf_rdata_b_i,
  input logic [XLEN-1:0]   op_a_o,
  input logic [XLEN-1:0]   op_b_o,
  input logic              carry_o,
  input logic              out_valid_o
);
  localparam logic [RIDX_W-1:0] PC_SEL = RIDX_W'(PC_IDX);
  logic acc_imm, acc_reg;
  assign acc_imm = in_valid_i && in_ready_o && !shift_by_reg_i;
  assign acc_reg = in_valid_i && in_ready_o && shift_by_reg_i;

  AST_IMM_SAME_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_imm |-> out_valid_o);  // R1
  AST_REG_FIRST_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_reg |-> (!out_valid_o && rf_raddr_a_o == rs_i));  // R2
  AST_REG_SECOND_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_reg |=> (out_valid_o && !in_ready_o));  // R2
  AST_BUSY_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o |=> in_ready_o);  // R12
  AST_IMM_PC_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_imm && rn_i == PC_SEL) |-> op_a_o == instr_addr_i + XLEN'(8));  // R3
  AST_REG_PC_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_reg && rn_i == PC_SEL) |=> op_a_o == $past(instr_addr_i) + XLEN'(12));  // R4
  AST_ZERO_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_imm && shift_imm_i == 5'd0 && rm_i != PC_SEL)
      |-> (op_b_o == rf_rdata_b_i && carry_o == carry_i));  // R6
endmodule

bind operand_fetch_shift opf_checker u_opf_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .in_valid_i    (in_valid_i),
  .in_ready_o    (in_ready_o),
  .rn_i          (rn_i),
  .rm_i          (rm_i),
  .rs_i          (rs_i),
  .shift_by_reg_i(shift_by_reg_i),
  .shift_imm_i   (shift_imm_i),
  .carry_i       (carry_i),
  .instr_addr_i  (instr_addr_i),
  .rf_raddr_a_o  (rf_raddr_a_o),
  .rf_rdata_b_i  (rf_rdata_b_i),
  .op_a_o        (op_a_o),
  .op_b_o        (op_b_o),
  .carry_o       (carry_o),
  .out_valid_o   (out_valid_o)
);

// File: tb/operand_fetch_shift_tb_top.sv
`timescale 1ns/1ps
module operand_fetch_shift_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic [3:0]  rn = '0, rm = '0, rs = '0;
  logic [1:0]  sh_type = '0;
  logic        by_reg = 1'b0;
  logic [4:0]  imm = '0;
  logic        cin = 1'b0;
  logic [31:0] addr = '0;
  logic [3:0]  ra_a, ra_b;
  logic [31:0] rd_a, rd_b, op_a, op_b;
  logic        cout, out_valid;
  logic [31:0] regs [16];
  int          n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  assign rd_a = (ra_a == 4'd15) ? 32'hDEAD_BEEF : regs[ra_a];
  assign rd_b = (ra_b == 4'd15) ? 32'hDEAD_BEEF : regs[ra_b];

  operand_fetch_shift dut_i (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .rn_i(rn), .rm_i(rm), .rs_i(rs), .shift_type_i(sh_type), .shift_by_reg_i(by_reg),
    .shift_imm_i(imm), .carry_i(cin), .instr_addr_i(addr),
    .rf_raddr_a_o(ra_a), .rf_raddr_b_o(ra_b), .rf_rdata_a_i(rd_a), .rf_rdata_b_i(rd_b),
    .op_a_o(op_a), .op_b_o(op_b), .carry_o(cout), .out_valid_o(out_valid)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bit-serial reference: shift one position per step
  function automatic logic [32:0] ref_shift(logic [31:0] v, logic [1:0] t, logic [7:0] n, logic c);
    logic [31:0] r = v;
    logic        cy = c;
    for (int i = 0; i < int'(n); i++) begin
      case (t)
        2'd0: begin cy = r[31]; r = {r[30:0], 1'b0}; end
        2'd1: begin cy = r[0];  r = {1'b0, r[31:1]}; end
        2'd2: begin cy = r[0];  r = {r[31], r[31:1]}; end
        default: begin cy = r[0]; r = {r[0], r[31:1]}; end
      endcase
    end
    return {cy, r};
  endfunction

  function automatic string treq(logic [1:0] t);
    case (t)
      2'd0: return "R7";
      2'd1: return "R8";
      2'd2: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic do_imm(logic [3:0] a, logic [3:0] b, logic [1:0] t, logic [4:0] n,
                        logic c, logic [31:0] ad, string tag);
    logic [31:0] ea, eb;
    logic [32:0] r;
    @(negedge clk);
    in_valid = 1'b1; by_reg = 1'b0; rn = a; rm = b; sh_type = t; imm = n; cin = c; addr = ad;
    #1;
    ea = (a == 4'd15) ? ad + 32'd8 : regs[a];
    eb = (b == 4'd15) ? ad + 32'd8 : regs[b];
    r  = ref_shift(eb, t, {3'b0, n}, c);
    chk("R1 valid", {31'b0, out_valid}, 32'd1);
    chk("R1 port_a", {28'b0, ra_a}, {28'b0, a});
    chk({tag, " op_a"}, op_a, ea);
    chk({tag, " op_b"}, op_b, r[31:0]);
    chk({tag, " carry"}, {31'b0, cout}, {31'b0, r[32]});
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic do_reg(logic [3:0] a, logic [3:0] b, logic [3:0] s, logic [1:0] t,
                        logic c, logic [31:0] ad, string tag);
    logic [31:0] ea, eb, ev;
    logic [32:0] r;
    @(negedge clk);
    in_valid = 1'b1; by_reg = 1'b1; rn = a; rm = b; rs = s; sh_type = t; cin = c; addr = ad;
    #1;
    chk("R2 no early valid", {31'b0, out_valid}, 32'd0);
    chk("R2 port_a rs", {28'b0, ra_a}, {28'b0, s});
    ev = (s == 4'd15) ? ad + 32'd8 : regs[s];
    @(negedge clk);
    // R12: unrelated request while busy
    in_valid = 1'b1; by_reg = 1'b0; rn = ~a; rm = ~b; rs = ~s; sh_type = ~t; cin = ~c;
    addr = ~ad; imm = 5'd3;
    #1;
    ea = (a == 4'd15) ? ad + 32'd12 : regs[a];
    eb = (b == 4'd15) ? ad + 32'd12 : regs[b];
    r  = ref_shift(eb, t, ev[7:0], c);
    chk("R2 valid", {31'b0, out_valid}, 32'd1);
    chk("R12 busy", {31'b0, in_ready}, 32'd0);
    chk({tag, " op_a"}, op_a, ea);
    chk({tag, " op_b"}, op_b, r[31:0]);
    chk({tag, " carry"}, {31'b0, cout}, {31'b0, r[32]});
    in_valid = 1'b0;
    @(negedge clk);
    chk("R12 ready again", {31'b0, in_ready}, 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) regs[i] = $urandom;
    #1;
    chk("R11 valid", {31'b0, out_valid}, 32'd0);
    chk("R11 ready", {31'b0, in_ready}, 32'd1);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R11 valid", {31'b0, out_valid}, 32'd0);
    chk("R11 ready", {31'b0, in_ready}, 32'd1);

    // program counter as operand
    do_imm(4'd15, 4'd15, 2'd0, 5'd0, 1'b1, 32'h0000_1000, "R3");
    do_imm(4'd15, 4'd2, 2'd1, 5'd4, 1'b0, 32'h0000_2000, "R3");
    do_imm(4'd1, 4'd15, 2'd3, 5'd8, 1'b0, 32'h0800_0100, "R3");
    do_reg(4'd15, 4'd15, 4'd3, 2'd0, 1'b0, 32'h0000_3000, "R4");
    do_reg(4'd15, 4'd5, 4'd15, 2'd1, 1'b1, 32'h0000_0004, "R4");
    do_reg(4'd6, 4'd15, 4'd7, 2'd3, 1'b0, 32'h0000_4444, "R4");
    // zero amount
    regs[3] = 32'h8000_0001;
    do_imm(4'd1, 4'd3, 2'd2, 5'd0, 1'b1, 32'h0, "R6");
    regs[4] = 32'hFFFF_FF00;
    do_reg(4'd1, 4'd3, 4'd4, 2'd1, 1'b0, 32'h0, "R6 R5");
    // boundary amounts 32, 33, 255, with high bits set (R5)
    for (int t = 0; t < 4; t++) begin
      regs[4] = 32'h1234_5620; do_reg(4'd2, 4'd3, 4'd4, 2'(t), 1'b0, 32'h0, {"R5 ", treq(2'(t))});
      regs[4] = 32'hABCD_EF21; do_reg(4'd2, 4'd3, 4'd4, 2'(t), 1'b1, 32'h0, treq(2'(t)));
      regs[4] = 32'h0000_00FF; do_reg(4'd2, 4'd3, 4'd4, 2'(t), 1'b0, 32'h0, treq(2'(t)));
      regs[4] = 32'h0000_0040; do_reg(4'd2, 4'd3, 4'd4, 2'(t), 1'b1, 32'h0, treq(2'(t)));
    end
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [1:0] t;
      for (int k = 0; k < 16; k++) regs[k] = $urandom;
      t = 2'($urandom);
      if ($urandom % 2 == 0)
        do_imm(4'($urandom), 4'($urandom), t, 5'($urandom), 1'($urandom),
               $urandom & 32'hFFFF_FFFC, treq(t));
      else begin
        regs[$urandom % 15] = $urandom % 80;
        do_reg(4'($urandom), 4'($urandom), 4'($urandom), t, 1'($urandom),
               $urandom & 32'hFFFF_FFFC, treq(t));
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule